// File: doc/BRIEF.md
# Word/Doubleword Integer ALU with Sign Extension

This block is an integer arithmetic unit for a machine whose registers are 64 bits wide. It runs two kinds of operation, addition and left shift. Each comes in a doubleword form that works on the full register width and a word form that works on the low 32 bits. A word result is always returned sign-extended to the full register width, so a later word operation can read it as a canonical value.

A word addition is only defined when both inputs are canonical. An input is canonical when its upper half repeats bit 31. The unit raises a flag when a word addition reads a non-canonical input, and it still returns the sign-extended low-word sum, so the result stays deterministic. Word left shifts look only at the low word of their operand, so they never raise the flag.

Operations enter through a valid/ready request stream and leave through a valid/ready result stream, with one register stage between them. A request is taken on a rising edge where `in_valid` and `in_ready` are both high. Its result appears on the next cycle. A result is consumed on an edge where `out_valid` and `out_ready` are both high. While a result waits with `out_ready` low, it stays frozen and `in_ready` is low. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. The producer must hold its request stable until it is taken.

Top module: `ws_alu`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: A request accepted on an edge shows its result and flag on the next cycle. While `out_valid` is 1 and `out_ready` is 0, the result and flag hold and `in_ready` is 0. When a result drains and a new request is accepted on the same edge, the new result follows with no gap.
- R3: Opcode 2'b00 (word add) returns the low 32 bits of `in_a + in_b`, sign-extended from bit 31 to 64 bits. For example, 0xffffffff80000000 plus itself gives 0.
- R4: Opcode 2'b01 (doubleword add) returns the 64-bit sum modulo 2^64. For example, 0xffffffff80000000 plus itself gives 0xffffffff00000000, and 0x80000000 plus itself gives 0x100000000.
- R5: Opcode 2'b10 (word shift left) shifts `in_a` left by `in_shamt[4:0]` and returns the low 32 bits, sign-extended. For example, 1 shifted by 31 gives 0xffffffff80000000, and 0x80000000 shifted by 0 gives 0xffffffff80000000.
- R6: Opcode 2'b11 (doubleword shift left) shifts `in_a` left by the full 6-bit `in_shamt`. For example, 1 shifted by 31 gives 0x80000000, and a shift by 0 returns the operand unchanged.
- R7: A word add raises `out_unpred` when `in_a` or `in_b` is non-canonical, meaning bits 63..32 are not all equal to bit 31. The result is still the value R3 defines. Adding 0x80000000 to itself as a word add raises the flag.
- R8: `out_unpred` is 0 for a word add of canonical inputs, and for every doubleword add, word shift and doubleword shift, whatever the operand values.
- R9: For a word shift, `in_shamt[5]`, bits 63..32 of `in_a`, and `in_b` have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| in_op | input | 2 | 00 word add, 01 doubleword add, 10 word shift left, 11 doubleword shift left |
| in_a | input | 64 | First operand, or the value to shift |
| in_b | input | 64 | Second operand for adds |
| in_shamt | input | 6 | Shift amount |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_result | output | 64 | Result value |
| out_unpred | output | 1 | Word add read a non-canonical input |

## Verification
Two of the block's functions can fall on the same edge: draining a waiting result and accepting the next request. The bench provokes this by stalling the output with `out_ready` low while a second request is held at the input. It then raises `out_ready` and checks that the first result stayed frozen during the stall. It also checks that the second result follows directly after the drain, with its own flag value. The arithmetic is judged by sweeps over every shift amount and over all pairs of a set of boundary operands. The expected values are computed in the bench from the requirement text.

// File: rtl/ws_alu_pkg.sv
package ws_alu_pkg;

  // bit 1 selects shift, bit 0 selects doubleword width
  typedef enum logic [1:0] {
    ALU_ADDW = 2'b00,
    ALU_ADDD = 2'b01,
    ALU_SLLW = 2'b10,
    ALU_SLLD = 2'b11
  } alu_op_e;

  function automatic logic op_is_shift(input alu_op_e op);
    return op[1];
  endfunction

  function automatic logic op_is_dword(input alu_op_e op);
    return op[0];
  endfunction

endpackage

// File: rtl/ws_canon_detect.sv
// Reports whether a register value is a sign-extended word.
module ws_canon_detect #(
  parameter int XLEN = 64,
  parameter int WLEN = 32
) (
  input  logic [XLEN-1:0] value,
  output logic            canonical
);
  localparam int UPW = XLEN - WLEN;

  logic [UPW-1:0] bit_match;

  for (genvar i = 0; i < UPW; i++) begin : g_cmp
    assign bit_match[i] = (value[WLEN + i] == value[WLEN-1]);
  end

  assign canonical = &bit_match;
endmodule

// File: rtl/ws_adder.sv
// Full-width adder shared by word and doubleword adds.
module ws_adder #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] lhs,
  input  logic [XLEN-1:0] rhs,
  output logic [XLEN-1:0] sum
);
  assign sum = lhs + rhs;
endmodule

// File: rtl/ws_shifter.sv
// Logarithmic left shifter, one stage per shift-amount bit.
module ws_shifter #(
  parameter int XLEN = 64,
  parameter int SHW  = $clog2(XLEN)
) (
  input  logic [XLEN-1:0] din,
  input  logic [SHW-1:0]  amount,
  output logic [XLEN-1:0] dout
);
  logic [XLEN-1:0] stage [0:SHW];

  assign stage[0] = din;

  for (genvar s = 0; s < SHW; s++) begin : g_stage
    localparam int STEP = 1 << s;
    assign stage[s+1] = amount[s] ? {stage[s][XLEN-1-STEP:0], {STEP{1'b0}}}
                                  : stage[s];
  end

  assign dout = stage[SHW];
endmodule

// File: rtl/ws_alu.sv
module ws_alu #(
  parameter int XLEN = 64,
  parameter int WLEN = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [1:0]              in_op,
  input  logic [XLEN-1:0]         in_a,
  input  logic [XLEN-1:0]         in_b,
  input  logic [$clog2(XLEN)-1:0] in_shamt,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [XLEN-1:0]         out_result,
  output logic                    out_unpred
);
  import ws_alu_pkg::*;

  localparam int SHW  = $clog2(XLEN);
  localparam int WSHW = $clog2(WLEN);
  localparam int UPW  = XLEN - WLEN;

  alu_op_e op;
  assign op = alu_op_e'(in_op);

  // canonical-input detection
  logic a_canon, b_canon;

  ws_canon_detect #(.XLEN(XLEN), .WLEN(WLEN)) u_canon_a (
    .value(in_a), .canonical(a_canon)
  );
  ws_canon_detect #(.XLEN(XLEN), .WLEN(WLEN)) u_canon_b (
    .value(in_b), .canonical(b_canon)
  );

  // arithmetic datapath
  logic [XLEN-1:0] add_sum;
  logic [XLEN-1:0] shl_out;
  logic [SHW-1:0]  shamt_eff;

  ws_adder #(.XLEN(XLEN)) u_adder (
    .lhs(in_a), .rhs(in_b), .sum(add_sum)
  );

  // word shifts keep only the low shift-amount bits
  assign shamt_eff = op_is_dword(op)
                   ? in_shamt
                   : {{(SHW-WSHW){1'b0}}, in_shamt[WSHW-1:0]};

  ws_shifter #(.XLEN(XLEN), .SHW(SHW)) u_shifter (
    .din(in_a), .amount(shamt_eff), .dout(shl_out)
  );

  // result select and word sign extension
  logic [XLEN-1:0] raw_res;
  logic [XLEN-1:0] nxt_res;
  logic            nxt_unpred;

  always_comb begin
    raw_res = op_is_shift(op) ? shl_out : add_sum;
    if (op_is_dword(op)) begin
      nxt_res = raw_res;
    end else begin
      nxt_res = {{UPW{raw_res[WLEN-1]}}, raw_res[WLEN-1:0]};
    end
    nxt_unpred = (op == ALU_ADDW) && !(a_canon && b_canon);
  end

  // single output register stage with pass-through ready
  logic take;
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_unpred <= 1'b0;
    end else begin
      if (take) begin
        out_valid  <= 1'b1;
        out_result <= nxt_res;
        out_unpred <= nxt_unpred;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ws_alu_chk.sv
module ws_alu_chk #(
  parameter int XLEN = 64,
  parameter int WLEN = 32
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic                    in_ready,
  input logic [1:0]              in_op,
  input logic [XLEN-1:0]         in_a,
  input logic [XLEN-1:0]         in_b,
  input logic [$clog2(XLEN)-1:0] in_shamt,
  input logic                    out_valid,
  input logic                    out_ready,
  input logic [XLEN-1:0]         out_result,
  input logic                    out_unpred
);
  logic acc;
  assign acc = in_valid && in_ready;

  // R2
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) && $stable(out_unpred)));

  // R2
  free_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  // R3 and R5: word forms come out sign-extended
  word_sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !in_op[0]) |=> (out_result[XLEN-1:WLEN] == {(XLEN-WLEN){out_result[WLEN-1]}}));

  // R4
  dadd_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_op == 2'b01) |=> (out_result == $past(in_a + in_b)));

  // R7
  flag_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_op == 2'b00 &&
     in_a[XLEN-1:WLEN] != {(XLEN-WLEN){in_a[WLEN-1]}}) |=> out_unpred);

  // R8
  quiet_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_op != 2'b00) |=> !out_unpred);
endmodule

bind ws_alu ws_alu_chk #(.XLEN(XLEN), .WLEN(WLEN)) u_ws_alu_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_op(in_op), .in_a(in_a), .in_b(in_b), .in_shamt(in_shamt),
  .out_valid(out_valid), .out_ready(out_ready),
  .out_result(out_result), .out_unpred(out_unpred)
);

// File: tb/test_ws_alu.sv
module test_ws_alu;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_op = 2'b00;
  logic [63:0] in_a = '0;
  logic [63:0] in_b = '0;
  logic [5:0]  in_shamt = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_result;
  logic        out_unpred;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ws_alu i_ws_alu (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_a(in_a), .in_b(in_b), .in_shamt(in_shamt),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result), .out_unpred(out_unpred)
  );

  function automatic logic [63:0] sx(input logic [31:0] w);
    return {{32{w[31]}}, w};
  endfunction

  function automatic logic canon(input logic [63:0] v);
    return v == sx(v[31:0]);
  endfunction

  // reference value from the requirement text
  function automatic logic [64:0] model(input logic [1:0] op, input logic [63:0] a,
                                        input logic [63:0] b, input logic [5:0] sh);
    logic [31:0] w;
    case (op)
      2'b00: begin
        w = a[31:0] + b[31:0];
        return {!(canon(a) && canon(b)), sx(w)};
      end
      2'b01: return {1'b0, a + b};
      2'b10: begin
        w = a[31:0] << sh[4:0];
        return {1'b0, sx(w)};
      end
      default: return {1'b0, a << sh};
    endcase
  endfunction

  task automatic check(input logic ok, input string tag,
                       input logic [64:0] act, input logic [64:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one request with out_ready high, result sampled a cycle later
  task automatic run_op(input logic [1:0] op, input logic [63:0] a, input logic [63:0] b,
                        input logic [5:0] sh, input string tag);
    logic [64:0] exp;
    exp = model(op, a, b, sh);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_a = a; in_b = b; in_shamt = sh;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid && {out_unpred, out_result} == exp, tag,
          {out_unpred, out_result}, exp);
  endtask

  task automatic run_fixed(input logic [1:0] op, input logic [63:0] a, input logic [63:0] b,
                           input logic [5:0] sh, input logic [63:0] er, input logic eu,
                           input string tag);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_a = a; in_b = b; in_shamt = sh;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid && out_result == er && out_unpred == eu, tag,
          {out_unpred, out_result}, {eu, er});
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [63:0] pats [10];
    logic [64:0] e1;
    logic [64:0] e2;
    pats = '{64'h0, 64'h1, 64'h7fffffff, 64'h80000000, 64'hffffffff80000000,
             64'hffffffffffffffff, 64'h100000000, 64'h40000000,
             64'h8000000000000000, 64'hdeadbeef12345678};

    repeat (3) @(negedge clk);
    // R1
    check(!out_valid && in_ready, "R1 reset", {63'b0, out_valid, in_ready}, 65'h1);
    rst_n = 1'b1;

    // fixed examples
    run_fixed(2'b00, 64'hffffffff80000000, 64'hffffffff80000000, 0, 64'h0, 0, "R3 wadd wrap");
    run_fixed(2'b01, 64'hffffffff80000000, 64'hffffffff80000000, 0, 64'hffffffff00000000, 0, "R4 dadd neg");
    run_fixed(2'b01, 64'h80000000, 64'h80000000, 0, 64'h100000000, 0, "R4 dadd carry");
    run_fixed(2'b10, 64'h1, 64'h0, 31, 64'hffffffff80000000, 0, "R5 wsll 31");
    run_fixed(2'b10, 64'h80000000, 64'h0, 0, 64'hffffffff80000000, 0, "R5 R9 wsll 0");
    run_fixed(2'b11, 64'h1, 64'h0, 31, 64'h80000000, 0, "R6 dsll 31");
    run_fixed(2'b11, 64'h80000000, 64'h0, 0, 64'h80000000, 0, "R6 dsll 0");
    run_fixed(2'b00, 64'h80000000, 64'h80000000, 0, 64'h0, 1, "R7 wadd noncanon");
    run_fixed(2'b00, 64'h40000000, 64'h1, 0, 64'h40000001, 0, "R8 wadd canon");
    // R9: upper bits, shamt[5] and in_b ignored by word shift
    run_fixed(2'b10, 64'h1234567800000003, 64'hffff, 6'd33, 64'h6, 0, "R9 wsll ignore");

    // operand-pair sweep over adds (R3 R4 R7 R8)
    for (int i = 0; i < 10; i++)
      for (int j = 0; j < 10; j++) begin
        run_op(2'b00, pats[i], pats[j], 0, "R3 R7 wadd sweep");
        run_op(2'b01, pats[i], pats[j], 0, "R4 R8 dadd sweep");
      end

    // every shift amount (R5 R6 R8 R9)
    for (int i = 0; i < 10; i++)
      for (int s = 0; s < 64; s++) begin
        run_op(2'b10, pats[i], pats[(i+3)%10], 6'(s), "R5 R9 wsll sweep");
        run_op(2'b11, pats[i], pats[(i+3)%10], 6'(s), "R6 dsll sweep");
      end

    // R2: stall, hold, then drain and accept on one edge
    e1 = model(2'b00, 64'h80000000, 64'h1, 0);
    e2 = model(2'b01, 64'h5, 64'h7, 0);
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_op = 2'b00; in_a = 64'h80000000; in_b = 64'h1;
    @(negedge clk);
    in_op = 2'b01; in_a = 64'h5; in_b = 64'h7;
    repeat (3) begin
      @(negedge clk);
      check(out_valid && !in_ready && {out_unpred, out_result} == e1, "R2 stall hold",
            {out_unpred, out_result}, e1);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid && {out_unpred, out_result} == e2, "R2 drain and accept",
          {out_unpred, out_result}, e2);
    @(negedge clk);
    check(!out_valid && in_ready, "R2 empty after drain",
          {63'b0, out_valid, in_ready}, 65'h1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule